// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in without any clock. The result is a 16-bit sum and a carry-out. The operand width is divided into four 4-bit slices. Inside each slice, the carries come from flattened sum-of-products lookahead terms built from per-bit generate (AND) and propagate (XOR) signals. No carry passes from bit to bit.

Each slice reports a block propagate and a block generate to a second-level carry unit. That unit applies the same flattened equations to the four slice pairs. It returns the carries into slices 1 to 3 and the final carry-out. It also returns a block propagate and a block generate for the whole 16-bit span, and both appear on the ports. A wider datapath can therefore cascade the adder under a further lookahead level. There is no state, and so there are no states or transitions to name. The output settles one combinational path after any input change.

Top module: `cla_adder16`

## Requirements
- R1: For every input combination, {cout_o, sum_o} equals a_i + b_i + cin_i taken as a 17-bit unsigned sum.
- R2: With a_i = 16'hFFFF, b_i = 16'h0000 and cin_i = 1, the carry-in travels through all sixteen bits: sum_o = 16'h0000 and cout_o = 1.
- R3: grp_p_o is 1 exactly when every bit pair of a_i and b_i differs, that is when (a_i ^ b_i) == 16'hFFFF.
- R4: grp_g_o is 1 exactly when a_i + b_i with a zero carry-in overflows 16 bits. The value of cin_i has no effect on grp_g_o.
- R5: cout_o always equals grp_g_o | (grp_p_o & cin_i).
- R6: A generate in the top slice alone (a_i = b_i = 16'h8000, cin_i = 0) gives sum_o = 0, cout_o = 1 and grp_g_o = 1.
- R7: A carry produced in one slice reaches the next slice (for example 16'h000F + 16'h0001 gives 16'h0010, and 16'h0FFF + 16'h0001 gives 16'h1000, with cout_o = 0).
- R8: With both operands zero, sum_o equals cin_i and cout_o, grp_p_o and grp_g_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_p_o | output | 1 | Propagate for the whole 16-bit span |
| grp_g_o | output | 1 | Generate for the whole 16-bit span |

## Verification
The embedded checks run on every input change. They compare each slice's flattened carries with a bit-serial recomputation, and they tie the carry unit's carry-out to its block signals. They also match the full result against a plain 17-bit addition and the span propagate against the operand XOR. What those checks cannot show is that the operand patterns which stress the lookahead paths actually occur. Such patterns include a carry travelling through all sixteen bits, a generate confined to the top slice, and carries crossing each slice boundary. Only the bench's directed cases and its random vectors, biased toward nibbles of all ones, drive the adder through those paths.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int unsigned CLA_WIDTH   = 16;
    localparam int unsigned CLA_SLICE_W = 4;

    typedef struct packed {
        logic prop;
        logic gen;
    } pg_pair_t;
endpackage

// File: rtl/cla_slice.sv
module cla_slice #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         blk_p,
    output logic         blk_g
);
    logic [W-1:0] g_bit, p_bit;
    logic [W:0]   carry;

    assign g_bit = a & b;
    assign p_bit = a ^ b;

    // flattened lookahead: every carry is an independent sum of products
    always_comb begin
        carry[0] = cin;
        for (int i = 0; i < W; i++) begin
            logic term;
            logic acc;
            term = cin;
            for (int j = 0; j <= i; j++) term = term & p_bit[j];
            acc = term;
            for (int j = 0; j <= i; j++) begin
                term = g_bit[j];
                for (int k = j + 1; k <= i; k++) term = term & p_bit[k];
                acc = acc | term;
            end
            carry[i+1] = acc;
        end
    end

    always_comb begin
        logic term;
        logic acc;
        acc = 1'b0;
        for (int j = 0; j < W; j++) begin
            term = g_bit[j];
            for (int k = j + 1; k < W; k++) term = term & p_bit[k];
            acc = acc | term;
        end
        blk_g = acc;
    end

    assign blk_p = &p_bit;
    assign sum   = p_bit ^ carry[W-1:0];

    // bit-serial recomputation used only by the check below
    logic [W:0] chain_ref;
    always_comb begin
        chain_ref[0] = cin;
        for (int i = 0; i < W; i++)
            chain_ref[i+1] = g_bit[i] | (p_bit[i] & chain_ref[i]);
    end

    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            // R1
            slice_chain_chk: assert (carry == chain_ref)
                else $error("slice carries %b differ from chained %b", carry, chain_ref);
        end
    end
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] grp_p,
    input  logic [N-1:0] grp_g,
    input  logic         cin,
    output logic [N:0]   carry,
    output logic         top_p,
    output logic         top_g
);
    always_comb begin
        carry[0] = cin;
        for (int i = 0; i < N; i++) begin
            logic term;
            logic acc;
            term = cin;
            for (int j = 0; j <= i; j++) term = term & grp_p[j];
            acc = term;
            for (int j = 0; j <= i; j++) begin
                term = grp_g[j];
                for (int k = j + 1; k <= i; k++) term = term & grp_p[k];
                acc = acc | term;
            end
            carry[i+1] = acc;
        end
    end

    always_comb begin
        logic term;
        logic acc;
        acc = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = grp_g[j];
            for (int k = j + 1; k < N; k++) term = term & grp_p[k];
            acc = acc | term;
        end
        top_g = acc;
    end

    assign top_p = &grp_p;

    always_comb begin
        if (!$isunknown({grp_p, grp_g, cin})) begin
            // R5
            unit_cout_chk: assert (carry[N] == (top_g | (top_p & cin)))
                else $error("carry-out %b disagrees with span P/G", carry[N]);
        end
    end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH   = CLA_WIDTH,
    parameter int unsigned SLICE_W = CLA_SLICE_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             grp_p_o,
    output logic             grp_g_o
);
    localparam int unsigned NSLICE = WIDTH / SLICE_W;

    pg_pair_t [NSLICE-1:0] slice_pg;
    logic [NSLICE-1:0]     s_p, s_g;
    logic [NSLICE:0]       s_carry;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        cla_slice #(.W(SLICE_W)) u_slice (
            .a     (a_i[s*SLICE_W +: SLICE_W]),
            .b     (b_i[s*SLICE_W +: SLICE_W]),
            .cin   (s_carry[s]),
            .sum   (sum_o[s*SLICE_W +: SLICE_W]),
            .blk_p (slice_pg[s].prop),
            .blk_g (slice_pg[s].gen)
        );
        assign s_p[s] = slice_pg[s].prop;
        assign s_g[s] = slice_pg[s].gen;
    end

    cla_carry_unit #(.N(NSLICE)) u_lcu (
        .grp_p (s_p),
        .grp_g (s_g),
        .cin   (cin_i),
        .carry (s_carry),
        .top_p (grp_p_o),
        .top_g (grp_g_o)
    );

    assign cout_o = s_carry[NSLICE];

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            // R1
            add_match_chk: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i)))
                else $error("sum mismatch");
            // R3
            span_prop_chk: assert (grp_p_o == ((a_i ^ b_i) == {WIDTH{1'b1}}))
                else $error("span propagate mismatch");
        end
    end
endmodule

// File: tb/tb_cla_adder16.sv
module tb_cla_adder16;
    logic        clk = 1'b0;
    logic [15:0] a, b;
    logic        cin;
    logic [15:0] sum;
    logic        cout, gp, gg;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cla_adder16 dut (
        .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout), .grp_p_o(gp), .grp_g_o(gg)
    );

    function automatic logic [16:0] ref_add(logic [15:0] x, logic [15:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {16'd0, c};
    endfunction

    function automatic logic ref_gp(logic [15:0] x, logic [15:0] y);
        return (x ^ y) == 16'hFFFF;
    endfunction

    function automatic logic ref_gg(logic [15:0] x, logic [15:0] y);
        logic [16:0] t;
        t = {1'b0, x} + {1'b0, y};
        return t[16];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] x, logic [15:0] y, logic c);
        @(negedge clk);
        a = x; b = y; cin = c;
        @(posedge clk);
        #1;
    endtask

    task automatic full_check(logic [15:0] x, logic [15:0] y, logic c);
        apply(x, y, c);
        check("R1", {15'd0, cout, sum}, {15'd0, ref_add(x, y, c)});
        check("R3", {31'd0, gp}, {31'd0, ref_gp(x, y)});
        check("R4", {31'd0, gg}, {31'd0, ref_gg(x, y)});
        check("R5", {31'd0, cout}, {31'd0, gg | (gp & c)});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] x, y;
        a = '0; b = '0; cin = 1'b0;
        void'($urandom(32'h1CA5));

        // R8: zero operands, both carry-in values
        apply(16'h0000, 16'h0000, 1'b0);
        check("R8", {28'd0, cout, gp, gg, 1'b0}, 32'd0);
        check("R8", {16'd0, sum}, 32'd0);
        apply(16'h0000, 16'h0000, 1'b1);
        check("R8", {16'd0, sum}, 32'd1);
        check("R8", {29'd0, cout, gp, gg}, 32'd0);

        // R2: carry-in through all sixteen bits
        apply(16'hFFFF, 16'h0000, 1'b1);
        check("R2", {15'd0, cout, sum}, 32'h10000);
        check("R3", {31'd0, gp}, 32'd1);

        // R6: generate only in top slice
        apply(16'h8000, 16'h8000, 1'b0);
        check("R6", {14'd0, gg, cout, sum}, 32'h30000);

        // R7: carries crossing slice boundaries
        apply(16'h000F, 16'h0001, 1'b0);
        check("R7", {15'd0, cout, sum}, 32'h00010);
        apply(16'h00FF, 16'h0001, 1'b0);
        check("R7", {15'd0, cout, sum}, 32'h00100);
        apply(16'h0FFF, 16'h0001, 1'b0);
        check("R7", {15'd0, cout, sum}, 32'h01000);

        // R4: cin does not change span generate
        apply(16'h7FFF, 16'h8000, 1'b1);
        check("R4", {31'd0, gg}, 32'd0);
        check("R5", {31'd0, cout}, 32'd1);
        apply(16'h7FFF, 16'h8000, 1'b0);
        check("R4", {31'd0, gg}, 32'd0);
        check("R5", {31'd0, cout}, 32'd0);

        full_check(16'hFFFF, 16'hFFFF, 1'b1);
        full_check(16'hAAAA, 16'h5555, 1'b0);
        full_check(16'hAAAA, 16'h5555, 1'b1);

        // R1: plain random vectors
        for (int n = 0; n < 2000; n++)
            full_check(16'($urandom), 16'($urandom), 1'($urandom));

        // R1: nibble-biased vectors that exercise long propagate runs
        for (int n = 0; n < 2000; n++) begin
            for (int s = 0; s < 4; s++) begin
                x[s*4 +: 4] = ($urandom % 2 == 0) ? 4'hF : 4'($urandom);
                y[s*4 +: 4] = ($urandom % 3 == 0) ? ~x[s*4 +: 4] : 4'($urandom);
            end
            full_check(x, y, 1'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule